// File: doc/BRIEF.md
# Banked Buffer RAM Self-Test Engine

This engine checks a buffer RAM that is larger than the address window through which it can be reached. The RAM is split into banks. A bank-select output, which also carries an enable bit, chooses which bank the window currently maps. When a start pulse arrives, the engine works through four passes over every bank. First it writes a pattern. Then it checks that pattern. Then it clears every bank to zero. Finally it checks that every word reads back as zero.

Each word gets a pattern value built from two parts: a seed for the bank and the word's index in the window. So a bank-select fault and an address-line fault each give a value that is wrong, not just a value that was written twice. The engine stops at the first bad word. It then reports that the test failed, along with the bank and word offset of that word. A one-cycle done pulse marks the end of every run, whether it passed or failed.

The RAM port is a plain synchronous single-port interface: address, write enable, read enable, write data and read data. Read data returns one clock after the address is presented. The number of banks, the window depth, the data width and the seed step are parameters.

Top module: `mbist_engine`

## Requirements
- R1: The start input is acted on only while the engine is idle. A start pulse during a run has no effect on that run's sequence or on its length.
- R2: In the pattern-write pass, word j of bank i receives (i * SEED_STEP + j) modulo 2^DATA_W. SEED_STEP defaults to 0x1000.
- R3: The pattern-check pass reads every word and compares it against the value from R2. At the first word that differs, the run ends failed, and err_bank/err_word give that word's bank and offset.
- R4: After the pattern check succeeds, a zero-fill pass writes 0 to every word of every bank.
- R5: A final pass reads every word. The first nonzero word ends the run failed and reports its bank and offset.
- R6: Every RAM access is made with bank_en = 1 and bank_sel equal to the bank under test. bank_sel is updated in a cycle with no access, before that bank's first access. bank_en is 0 while idle.
- R7: Read data is taken one clock after the cycle in which mem_re and the address are presented.
- R8: done is high for exactly one cycle at the end of each run. fail and err_bank/err_word keep their values until the next accepted start, which clears them. After a passing run they are all zero.
- R9: Count edges from the edge that samples start to the edge that raises done. A passing run takes exactly 4 * (NUM_BANKS * (WIN_WORDS + 1) + 1) edges. A run that fails in read pass p (p = 1 for the pattern check, p = 3 for the zero check) at bank b, word o takes p * (NUM_BANKS * (WIN_WORDS + 1) + 1) + b * (WIN_WORDS + 1) + o + 3 edges.
- R10: After reset, done, fail, bank_en, mem_we and mem_re are 0, and err_bank and err_word are 0.
- R11: Every pass visits banks in ascending order, 0 first. Inside each bank it visits words in ascending order, 0 first, one word per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a test run (sampled while idle) |
| mem_addr | output | ADDR_W | Word address within the window |
| mem_we | output | 1 | Write strobe for the current word |
| mem_re | output | 1 | Read strobe for the current word |
| mem_wdata | output | DATA_W | Data to write |
| mem_rdata | input | DATA_W | Read data, valid one clock after mem_re |
| bank_sel | output | BANK_W | Bank mapped into the window |
| bank_en | output | 1 | Bank-select enable |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Run failed; held until next start |
| err_bank | output | BANK_W | Bank of the first failing word |
| err_word | output | ADDR_W | Offset of the first failing word |

## Verification
The engine is run against a RAM model into which one or two faults can be injected: bits stuck at one or at zero, and a location that ignores zero writes. Whether a stuck bit is caught in the pattern check or only in the zero check depends on which bits that location's pattern value has set, and the measured run length tells the two passes apart. A zero-drop fault at bank 0, word 0, whose pattern value is already 0, must pass, while the same fault at the last word must fail in the final pass. Faults at the first and the last word of the window exercise the compare that trails the final read. Two faults in one run show that only the first one in visiting order is reported.

// File: rtl/mbist_pkg.sv
// Package: shared state and pass encodings for the banked RAM self-test.
// Assumes: passes run in the enum order listed below; the controller
// relies on that order to step from one pass to the next.
package mbist_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEL    = 2'd1,
        ST_ACCESS = 2'd2,
        ST_DRAIN  = 2'd3
    } state_e;

    // Test passes, in execution order
    typedef enum logic [1:0] {
        PH_WR_PAT  = 2'd0,
        PH_RD_PAT  = 2'd1,
        PH_WR_ZERO = 2'd2,
        PH_RD_ZERO = 2'd3
    } phase_e;

    // True for the two passes that read and compare
    function automatic logic phase_reads(phase_e p);
        return (p == PH_RD_PAT) || (p == PH_RD_ZERO);
    endfunction

    // True for the two passes whose expected data is all zeros
    function automatic logic phase_zero(phase_e p);
        return (p == PH_WR_ZERO) || (p == PH_RD_ZERO);
    endfunction

endpackage

// File: rtl/mbist_walker.sv
// Module: bank / word position counters for the self-test.
// Walks words 0..WIN_WORDS-1 inside a bank, then banks 0..NUM_BANKS-1.
// Assumes: adv_bank is only raised together with adv_word on the last word.
module mbist_walker #(
    parameter int NUM_BANKS = 4,
    parameter int WIN_WORDS = 4096,
    parameter int BANK_W    = 2,
    parameter int ADDR_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              adv_word_i,
    input  logic              adv_bank_i,
    output logic [BANK_W-1:0] bank_o,
    output logic [ADDR_W-1:0] word_o,
    output logic              last_word_o,
    output logic              last_bank_o
);

    localparam logic [ADDR_W-1:0] WORD_MAX = ADDR_W'(WIN_WORDS - 1);
    localparam logic [BANK_W-1:0] BANK_MAX = BANK_W'(NUM_BANKS - 1);

    logic [BANK_W-1:0] bank_q;
    logic [ADDR_W-1:0] word_q;

    assign last_word_o = (word_q == WORD_MAX);
    assign last_bank_o = (bank_q == BANK_MAX);
    assign bank_o      = bank_q;
    assign word_o      = word_q;

    // Word counter: wraps to 0 after the last word of the window
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            word_q <= '0;
        end else if (adv_word_i) begin
            word_q <= last_word_o ? '0 : word_q + 1'b1;
        end
    end

    // Bank counter: wraps to 0 after the last bank so the next pass restarts
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            bank_q <= '0;
        end else if (adv_bank_i) begin
            bank_q <= last_bank_o ? '0 : bank_q + 1'b1;
        end
    end

endmodule

// File: rtl/mbist_pattern.sv
// Module: expected-data generator for the self-test.
// Pattern passes produce bank*SEED_STEP + word (mod 2^DATA_W);
// zero passes produce 0. Purely combinational.
// Assumes: SEED_STEP is non-negative; a power-of-two step is built as a shift.
module mbist_pattern
    import mbist_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int BANK_W    = 2,
    parameter int ADDR_W    = 12,
    parameter int SEED_STEP = 32'h1000
) (
    input  phase_e            phase_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [ADDR_W-1:0] word_i,
    output logic [DATA_W-1:0] data_o
);

    localparam bit STEP_POW2 = (SEED_STEP > 0) && ((SEED_STEP & (SEED_STEP - 1)) == 0);

    logic [DATA_W-1:0] seed;

    // Per-bank seed: a shift for power-of-two steps, a multiply otherwise
    generate
        if (STEP_POW2) begin : g_seed_shift
            localparam int SHIFT = $clog2(SEED_STEP);
            always_comb begin
                seed = DATA_W'(bank_i) << SHIFT;
            end
        end else begin : g_seed_mult
            localparam logic [DATA_W-1:0] STEP_V = DATA_W'(SEED_STEP);
            always_comb begin
                seed = DATA_W'(bank_i) * STEP_V;
            end
        end
    endgenerate

    // Final data: seed plus word index, or zero in the clearing passes
    always_comb begin
        if (phase_zero(phase_i)) begin
            data_o = '0;
        end else begin
            data_o = seed + DATA_W'(word_i);
        end
    end

endmodule

// File: rtl/mbist_compare.sv
// Module: one-stage read-compare pipeline for the self-test.
// Captures expected data and location in the cycle a read is issued and
// compares against read data one clock later (synchronous RAM latency).
// Assumes: flush_i is raised when the run aborts so no stale compare survives.
module mbist_compare #(
    parameter int DATA_W = 16,
    parameter int BANK_W = 2,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              flush_i,
    input  logic [DATA_W-1:0] exp_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [ADDR_W-1:0] word_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              mismatch_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [ADDR_W-1:0] word_o
);

    logic              pend_q;
    logic [DATA_W-1:0] exp_q;
    logic [BANK_W-1:0] bank_q;
    logic [ADDR_W-1:0] word_q;

    // Pending flag: one compare is due in the cycle after each issued read
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= load_i;
        end
    end

    // Expected data and location captured alongside the issued read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q  <= '0;
            bank_q <= '0;
            word_q <= '0;
        end else if (load_i) begin
            exp_q  <= exp_i;
            bank_q <= bank_i;
            word_q <= word_i;
        end
    end

    assign mismatch_o = pend_q && (rdata_i != exp_q);
    assign bank_o     = bank_q;
    assign word_o     = word_q;

endmodule

// File: rtl/mbist_ctrl.sv
// Module: sequencing controller for the self-test.
// Steps through the four passes; each bank is preceded by a select cycle
// and each pass is followed by a drain cycle so the last compare lands.
// Assumes: the walker wraps bank and word to 0 at the end of every pass.
module mbist_ctrl
    import mbist_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              last_word_i,
    input  logic              last_bank_i,
    input  logic [BANK_W-1:0] walk_bank_i,
    input  logic              mismatch_i,
    input  logic [BANK_W-1:0] mm_bank_i,
    input  logic [ADDR_W-1:0] mm_word_i,
    output phase_e            phase_o,
    output logic              walk_clr_o,
    output logic              adv_word_o,
    output logic              adv_bank_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    output logic              cmp_load_o,
    output logic              cmp_flush_o,
    output logic [BANK_W-1:0] bank_sel_o,
    output logic              bank_en_o,
    output logic              done_o,
    output logic              fail_o,
    output logic [BANK_W-1:0] err_bank_o,
    output logic [ADDR_W-1:0] err_word_o
);

    state_e            state_q;
    phase_e            phase_q;
    logic [BANK_W-1:0] bank_sel_q;
    logic              bank_en_q;
    logic              done_q;
    logic              fail_q;
    logic [BANK_W-1:0] err_bank_q;
    logic [ADDR_W-1:0] err_word_q;

    logic in_access;
    logic abort;
    logic rd_pass;

    // Access strobes and walker controls decoded from state and pass
    always_comb begin
        in_access   = (state_q == ST_ACCESS);
        rd_pass     = phase_reads(phase_q);
        abort       = mismatch_i && (state_q != ST_IDLE);
        mem_we_o    = in_access && !rd_pass;
        mem_re_o    = in_access && rd_pass && !abort;
        adv_word_o  = in_access && !abort;
        adv_bank_o  = in_access && !abort && last_word_i;
        cmp_load_o  = mem_re_o;
        cmp_flush_o = abort;
        walk_clr_o  = (state_q == ST_IDLE) && start_i;
    end

    // Main sequencer: state, pass, bank select and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            phase_q    <= PH_WR_PAT;
            bank_sel_q <= '0;
            bank_en_q  <= 1'b0;
            done_q     <= 1'b0;
            fail_q     <= 1'b0;
            err_bank_q <= '0;
            err_word_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (state_q == ST_IDLE) begin
                if (start_i) begin
                    state_q    <= ST_SEL;
                    phase_q    <= PH_WR_PAT;
                    fail_q     <= 1'b0;
                    err_bank_q <= '0;
                    err_word_q <= '0;
                end
            end else if (abort) begin
                state_q    <= ST_IDLE;
                bank_en_q  <= 1'b0;
                done_q     <= 1'b1;
                fail_q     <= 1'b1;
                err_bank_q <= mm_bank_i;
                err_word_q <= mm_word_i;
            end else begin
                unique case (state_q)
                    ST_SEL: begin
                        bank_sel_q <= walk_bank_i;
                        bank_en_q  <= 1'b1;
                        state_q    <= ST_ACCESS;
                    end
                    ST_ACCESS: begin
                        if (last_word_i) begin
                            state_q <= last_bank_i ? ST_DRAIN : ST_SEL;
                        end
                    end
                    ST_DRAIN: begin
                        if (phase_q == PH_RD_ZERO) begin
                            state_q   <= ST_IDLE;
                            bank_en_q <= 1'b0;
                            done_q    <= 1'b1;
                        end else begin
                            phase_q <= phase_e'(phase_q + 2'd1);
                            state_q <= ST_SEL;
                        end
                    end
                    default: begin
                        state_q <= ST_IDLE;
                    end
                endcase
            end
        end
    end

    assign phase_o    = phase_q;
    assign bank_sel_o = bank_sel_q;
    assign bank_en_o  = bank_en_q;
    assign done_o     = done_q;
    assign fail_o     = fail_q;
    assign err_bank_o = err_bank_q;
    assign err_word_o = err_word_q;

endmodule

// File: rtl/mbist_engine.sv
// Module: top of the banked buffer RAM self-test engine.
// Ties the walker, pattern generator, compare stage and controller to the
// RAM port, the bank-select outputs and the result outputs.
// Assumes: the RAM returns read data one clock after mem_re.
module mbist_engine
    import mbist_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int WIN_WORDS = 4096,
    parameter int DATA_W    = 16,
    parameter int SEED_STEP = 32'h1000,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W   = $clog2(WIN_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [BANK_W-1:0] bank_sel,
    output logic              bank_en,
    output logic              done,
    output logic              fail,
    output logic [BANK_W-1:0] err_bank,
    output logic [ADDR_W-1:0] err_word
);

    phase_e            phase;
    logic              walk_clr, adv_word, adv_bank;
    logic              last_word, last_bank;
    logic [BANK_W-1:0] walk_bank;
    logic [ADDR_W-1:0] walk_word;
    logic [DATA_W-1:0] exp_data;
    logic              cmp_load, cmp_flush, mismatch;
    logic [BANK_W-1:0] mm_bank;
    logic [ADDR_W-1:0] mm_word;

    mbist_walker #(
        .NUM_BANKS (NUM_BANKS),
        .WIN_WORDS (WIN_WORDS),
        .BANK_W    (BANK_W),
        .ADDR_W    (ADDR_W)
    ) walker_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (walk_clr),
        .adv_word_i  (adv_word),
        .adv_bank_i  (adv_bank),
        .bank_o      (walk_bank),
        .word_o      (walk_word),
        .last_word_o (last_word),
        .last_bank_o (last_bank)
    );

    mbist_pattern #(
        .DATA_W    (DATA_W),
        .BANK_W    (BANK_W),
        .ADDR_W    (ADDR_W),
        .SEED_STEP (SEED_STEP)
    ) pattern_i (
        .phase_i (phase),
        .bank_i  (walk_bank),
        .word_i  (walk_word),
        .data_o  (exp_data)
    );

    mbist_compare #(
        .DATA_W (DATA_W),
        .BANK_W (BANK_W),
        .ADDR_W (ADDR_W)
    ) compare_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cmp_load),
        .flush_i    (cmp_flush),
        .exp_i      (exp_data),
        .bank_i     (walk_bank),
        .word_i     (walk_word),
        .rdata_i    (mem_rdata),
        .mismatch_o (mismatch),
        .bank_o     (mm_bank),
        .word_o     (mm_word)
    );

    mbist_ctrl #(
        .BANK_W (BANK_W),
        .ADDR_W (ADDR_W)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .last_word_i (last_word),
        .last_bank_i (last_bank),
        .walk_bank_i (walk_bank),
        .mismatch_i  (mismatch),
        .mm_bank_i   (mm_bank),
        .mm_word_i   (mm_word),
        .phase_o     (phase),
        .walk_clr_o  (walk_clr),
        .adv_word_o  (adv_word),
        .adv_bank_o  (adv_bank),
        .mem_we_o    (mem_we),
        .mem_re_o    (mem_re),
        .cmp_load_o  (cmp_load),
        .cmp_flush_o (cmp_flush),
        .bank_sel_o  (bank_sel),
        .bank_en_o   (bank_en),
        .done_o      (done),
        .fail_o      (fail),
        .err_bank_o  (err_bank),
        .err_word_o  (err_word)
    );

    // RAM address and write data come straight from the walker and pattern
    assign mem_addr  = walk_word;
    assign mem_wdata = exp_data;

endmodule

// File: rtl/mbist_engine_chk.sv
// Module: port-level property checker for mbist_engine, attached by bind.
// Assumes: observes only the top-level ports; no internal state is used.
module mbist_engine_chk #(
    parameter int DATA_W = 16,
    parameter int BANK_W = 2,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              mem_re,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [BANK_W-1:0] bank_sel,
    input logic              bank_en,
    input logic              done,
    input logic              fail,
    input logic [BANK_W-1:0] err_bank,
    input logic [ADDR_W-1:0] err_word
);

    localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);
    localparam logic [DATA_W-1:0] D_ONE = DATA_W'(1);

    logic access;
    assign access = mem_we || mem_re;

    // R6
    access_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        access |-> bank_en);

    // R6
    select_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !$stable(bank_sel)) |-> !$past(access));

    // R7
    rw_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    fail_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> done);

    // R8
    pass_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fail |-> (err_bank == '0 && err_word == '0));

    // R6
    idle_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!bank_en && !access));

    // R11
    addr_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (access && $past(access) && $stable(bank_sel)) |-> (mem_addr == $past(mem_addr) + A_ONE));

    // R2
    wdata_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we) && $stable(bank_sel) && mem_wdata != '0)
            |-> (mem_wdata == $past(mem_wdata) + D_ONE));

endmodule

bind mbist_engine mbist_engine_chk #(
    .DATA_W (DATA_W),
    .BANK_W (BANK_W),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_wdata (mem_wdata),
    .bank_sel  (bank_sel),
    .bank_en   (bank_en),
    .done      (done),
    .fail      (fail),
    .err_bank  (err_bank),
    .err_word  (err_word)
);

// File: tb/mbist_engine_tb_top.sv
`timescale 1ns/1ps
// Bench: banked RAM model with fault injection, a vector table of faults
// and expected outcomes, then directed tests for reset, hold and corners.
module mbist_engine_tb_top;

    localparam int NB = 4;
    localparam int WW = 16;
    localparam int AW = 4;
    localparam int BW = 2;
    localparam int DEPTH = NB * WW;
    localparam int PASS_LAT = 4 * (NB * (WW + 1) + 1);   // 276

    // Fault kinds: 0 none, 1 stuck-at-one bits, 2 stuck-at-zero bits, 3 zero writes dropped
    typedef struct packed {
        logic [1:0]  kind;
        logic [1:0]  fbank;
        logic [3:0]  foff;
        logic [15:0] mask;
        logic        efail;
        logic [1:0]  ebank;
        logic [3:0]  eoff;
        logic [11:0] elat;
    } vec_t;

    localparam vec_t VEC [9] = '{
        '{2'd0, 2'd0, 4'd0,  16'h0000, 1'b0, 2'd0, 4'd0,  12'd276}, // clean: R2 R5 R9
        '{2'd1, 2'd2, 4'd5,  16'h0001, 1'b1, 2'd2, 4'd5,  12'd249}, // bit already set in pattern: R5
        '{2'd1, 2'd1, 4'd4,  16'h0002, 1'b1, 2'd1, 4'd4,  12'd93},  // caught in pattern check: R3
        '{2'd2, 2'd3, 4'd0,  16'h1000, 1'b1, 2'd3, 4'd0,  12'd123}, // seed bit stuck low: R3
        '{2'd2, 2'd0, 4'd7,  16'h0008, 1'b0, 2'd0, 4'd0,  12'd276}, // stuck-low bit never set: R3
        '{2'd3, 2'd0, 4'd0,  16'h0000, 1'b0, 2'd0, 4'd0,  12'd276}, // dropped zero, pattern is 0: R4
        '{2'd3, 2'd3, 4'd15, 16'h0000, 1'b1, 2'd3, 4'd15, 12'd276}, // dropped zero at last word: R4 R5
        '{2'd1, 2'd3, 4'd15, 16'h8000, 1'b1, 2'd3, 4'd15, 12'd138}, // last word, trailing compare: R3 R7
        '{2'd1, 2'd0, 4'd0,  16'h4000, 1'b1, 2'd0, 4'd0,  12'd72}   // first word: R3 R11
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_we, mem_re;
    logic [15:0]   mem_wdata;
    logic [15:0]   mem_rdata;
    logic [BW-1:0] bank_sel;
    logic          bank_en;
    logic          done, fail;
    logic [BW-1:0] err_bank;
    logic [AW-1:0] err_word;

    int n_checks = 0;
    int n_err    = 0;

    always #2.5 clk = ~clk;

    mbist_engine #(
        .NUM_BANKS (NB),
        .WIN_WORDS (WW),
        .DATA_W    (16),
        .SEED_STEP (32'h1000)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .bank_sel  (bank_sel),
        .bank_en   (bank_en),
        .done      (done),
        .fail      (fail),
        .err_bank  (err_bank),
        .err_word  (err_word)
    );

    // ---------------- RAM model with two fault slots ----------------
    logic [15:0] ram [DEPTH];
    logic [1:0]  f_kind [2];
    int          f_idx  [2];
    logic [15:0] f_mask [2];
    logic        snoop_clr = 1'b0;
    logic        seen [DEPTH];
    logic [15:0] first_val [DEPTH];

    int cur_idx;
    assign cur_idx = int'({bank_sel, mem_addr});

    function automatic logic [15:0] faulty_read(int idx, logic [15:0] v);
        logic [15:0] r = v;
        for (int s = 0; s < 2; s++) begin
            if (f_idx[s] == idx && f_kind[s] == 2'd1) r = r | f_mask[s];
            if (f_idx[s] == idx && f_kind[s] == 2'd2) r = r & ~f_mask[s];
        end
        return r;
    endfunction

    function automatic logic drops_write(int idx, logic [15:0] v);
        logic d = 1'b0;
        for (int s = 0; s < 2; s++) begin
            if (f_idx[s] == idx && f_kind[s] == 2'd3 && v == 16'h0) d = 1'b1;
        end
        return d;
    endfunction

    always_ff @(posedge clk) begin
        if (bank_en && mem_we && !drops_write(cur_idx, mem_wdata)) ram[cur_idx] <= mem_wdata;
        if (bank_en && mem_re) mem_rdata <= faulty_read(cur_idx, ram[cur_idx]);
        else                   mem_rdata <= 16'hDEAD;
    end

    // First value written to each location (observes R2 at the ports)
    always_ff @(posedge clk) begin
        if (snoop_clr) begin
            for (int k = 0; k < DEPTH; k++) seen[k] <= 1'b0;
        end else if (bank_en && mem_we && !seen[cur_idx]) begin
            seen[cur_idx]      <= 1'b1;
            first_val[cur_idx] <= mem_wdata;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_fault(input int s, input logic [1:0] kind, input int b, input int o,
                             input logic [15:0] mask);
        f_kind[s] = kind;
        f_idx[s]  = b * WW + o;
        f_mask[s] = mask;
    endtask

    logic fail_after_start;

    // Start a run; optionally pulse start again at edge count poke; return latency
    task automatic run(input int poke, output int lat);
        @(negedge clk);
        snoop_clr = 1'b1;
        @(negedge clk);
        snoop_clr = 1'b0;
        start = 1'b1;
        @(posedge clk);
        #1;
        start = 1'b0;
        fail_after_start = fail;
        lat = 0;
        while (!done && lat < 3000) begin
            @(posedge clk);
            #1;
            lat++;
            start = (lat == poke);
        end
        start = 1'b0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL R9 watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        int lat;
        int bad;
        set_fault(0, 2'd0, 0, 0, 16'h0);
        set_fault(1, 2'd0, 0, 0, 16'h0);
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        chk("R10 done", int'(done), 0);
        chk("R10 fail", int'(fail), 0);
        chk("R10 bank_en", int'(bank_en), 0);
        chk("R10 mem_we", int'(mem_we), 0);
        chk("R10 mem_re", int'(mem_re), 0);
        chk("R10 err", int'(err_bank) + int'(err_word), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table walk
        for (int v = 0; v < 9; v++) begin
            set_fault(0, VEC[v].kind, int'(VEC[v].fbank), int'(VEC[v].foff), VEC[v].mask);
            run(-1, lat);
            chk($sformatf("R9 R11 latency vec%0d", v), lat, int'(VEC[v].elat));
            chk($sformatf("R3 R5 fail vec%0d", v), int'(fail), int'(VEC[v].efail));
            chk($sformatf("R3 R5 err_bank vec%0d", v), int'(err_bank), int'(VEC[v].ebank));
            chk($sformatf("R3 R5 err_word vec%0d", v), int'(err_word), int'(VEC[v].eoff));
            @(posedge clk);
            #1;
            chk($sformatf("R8 done pulse vec%0d", v), int'(done), 0);
        end

        // R8: failure result holds while idle
        repeat (5) @(posedge clk);
        #1;
        chk("R8 fail held", int'(fail), 1);
        chk("R8 err_bank held", int'(err_bank), 0);
        chk("R8 err_word held", int'(err_word), 0);

        // R1: start during a run is ignored; R8: start clears fail
        set_fault(0, 2'd0, 0, 0, 16'h0);
        run(50, lat);
        chk("R8 fail cleared by start", int'(fail_after_start), 0);
        chk("R1 busy start ignored latency", lat, PASS_LAT);
        chk("R1 busy start pass", int'(fail), 0);
        @(posedge clk);
        #1;
        chk("R8 done single after busy start", int'(done), 0);
        chk("R6 bank_en low when idle", int'(bank_en), 0);

        // R4: every word zero after a passing run
        bad = 0;
        for (int k = 0; k < DEPTH; k++) if (ram[k] != 16'h0) bad++;
        chk("R4 nonzero words after run", bad, 0);

        // R2: first value written to bank b word o is b*0x1000+o
        bad = 0;
        for (int b = 0; b < NB; b++) begin
            for (int o = 0; o < WW; o++) begin
                if (!seen[b * WW + o] || first_val[b * WW + o] != 16'(b * 16'h1000 + o)) bad++;
            end
        end
        chk("R2 pattern words wrong", bad, 0);

        // R3: two faults, only the first in visiting order is reported
        set_fault(0, 2'd1, 2, 3, 16'h8000);
        set_fault(1, 2'd1, 1, 4, 16'h0002);
        run(-1, lat);
        chk("R3 first of two latency", lat, 93);
        chk("R3 first of two fail", int'(fail), 1);
        chk("R3 first of two bank", int'(err_bank), 1);
        chk("R3 first of two word", int'(err_word), 4);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule